// File: doc/BRIEF.md
# Equalization and Serration Composite Sync Generator

This block forms the raw composite sync of a video timing generator. Every cycle it takes the pixel position within the line, the line number and the field parity from the timing counters, plus the programmed line length, horizontal sync end, vertical sync line range and the equalization and serration settings. It emits composite sync before any output polarity is applied. Outside a programmed window of lines, composite sync is the horizontal sync pulse, and it is held active across the vertical sync lines. Inside the window, the normal pulse is replaced by narrow equalization pulses, or by serration pulses on the vertical sync lines.

A two-bit mode field selects the pulse rate and the field handling. In the double-rate modes a second pulse starts half a line after the first. The single-rate mode gives one pulse per line. The interlaced mode moves the odd field's window by half a line, so both fields receive the sequence. The reserved mode code turns the substitution off and raises a flag. Both outputs are registered.

Top module: `eqser_csync`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, csync_raw and mode_illegal are 0.
- R2: Outside the substitution window, csync_raw one cycle later equals (hpos < hsync_end) OR (vs_start <= vline < vs_end).
- R3: In the double-rate modes (mode 00 and 01), the pulse phase is hpos - line_len/2 when hpos >= line_len/2 (floor division), and hpos otherwise. Inside the window, csync_raw is 1 exactly when the phase is below the active width.
- R4: In single-rate mode 11, the phase is hpos. No second pulse appears at half line.
- R5: Inside the window, the active width is serr_end on lines with vs_start <= vline < vs_end, and eq_end on all other lines.
- R6: For even fields, and in every non-interlaced mode, the window covers the lines win_start <= vline < win_end. The start line is included and the end line is excluded.
- R7: In mode 00 with odd_field = 1, the window begins at hpos >= line_len/2 on line win_start and ends after hpos < line_len/2 on line win_end. The lines strictly between those two are fully inside the window.
- R8: In modes 01 and 11, odd_field has no effect on csync_raw.
- R9: When es_disable = 1, csync_raw follows the R2 rule on every line.
- R10: Mode code 10 disables substitution in the same way as es_disable. mode_illegal is 1 in the cycle after mode is 10, and 0 in the cycle after any other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hpos | input | 12 | Pixel position within the line |
| vline | input | 12 | Line number within the field |
| odd_field | input | 1 | 1 during the odd field |
| line_len | input | 12 | Clocks per line |
| hsync_end | input | 12 | End count of normal horizontal sync |
| vs_start | input | 12 | First vertical sync line |
| vs_end | input | 12 | Line after the last vertical sync line |
| mode | input | 2 | 00 interlaced double, 01 non-interlaced double, 10 reserved, 11 non-interlaced single |
| eq_end | input | 12 | Equalization pulse end count |
| serr_end | input | 12 | Serration pulse end count |
| win_start | input | 12 | First line of the substitution window |
| win_end | input | 12 | End line of the substitution window |
| es_disable | input | 1 | 1 turns substitution off |
| csync_raw | output | 1 | Composite sync, active high, before polarity |
| mode_illegal | output | 1 | Reserved mode code seen in the previous cycle |

## Verification
Each output is set by a single register. The values of csync_raw and mode_illegal for one set of inputs are therefore due one rising edge after those inputs are applied. The bench applies each input set shortly after an edge and computes the expected values from that set. It compares the outputs 1 ns after the next edge, before any input changes, so every comparison lines up with exactly one input set.

// File: rtl/eqser_csync.sv
module eqser_csync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hpos,
  input  logic [W-1:0] vline,
  input  logic         odd_field,
  input  logic [W-1:0] line_len,
  input  logic [W-1:0] hsync_end,
  input  logic [W-1:0] vs_start,
  input  logic [W-1:0] vs_end,
  input  logic [1:0]   mode,
  input  logic [W-1:0] eq_end,
  input  logic [W-1:0] serr_end,
  input  logic [W-1:0] win_start,
  input  logic [W-1:0] win_end,
  input  logic         es_disable,
  output logic         csync_raw,
  output logic         mode_illegal
);
  localparam logic [1:0] M_ILACE  = 2'b00;
  localparam logic [1:0] M_BAD    = 2'b10;
  localparam logic [1:0] M_SINGLE = 2'b11;

  logic [W-1:0] half, phase, width;
  logic in_vs, dbl, second, win_even, win_odd, in_win, use_es, nxt;

  assign half     = line_len >> 1;
  assign in_vs    = (vline >= vs_start) && (vline < vs_end);
  assign dbl      = (mode != M_SINGLE);
  assign second   = dbl && (hpos >= half);
  assign phase    = second ? hpos - half : hpos;
  assign width    = in_vs ? serr_end : eq_end;

  assign win_even = (vline >= win_start) && (vline < win_end);
  assign win_odd  = ((vline == win_start) && (hpos >= half)) ||
                    ((vline > win_start) && (vline < win_end)) ||
                    ((vline == win_end) && (hpos < half));
  assign in_win   = (mode == M_ILACE && odd_field) ? win_odd : win_even;
  assign use_es   = in_win && !es_disable && (mode != M_BAD);
  assign nxt      = use_es ? (phase < width) : ((hpos < hsync_end) || in_vs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csync_raw    <= 1'b0;
      mode_illegal <= 1'b0;
    end else begin
      csync_raw    <= nxt;
      mode_illegal <= (mode == M_BAD);
    end
  end

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !primed |-> (!csync_raw && !mode_illegal)); // R1
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (mode_illegal == ($past(mode) == 2'b10))); // R10
  AST_DISABLED_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(es_disable)) |->
      (csync_raw == (($past(hpos) < $past(hsync_end)) || $past(in_vs)))); // R9
  AST_SINGLE_NO_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(mode) == 2'b11 && !$past(es_disable) && $past(win_even) &&
     !$past(in_vs) && $past(hpos) >= $past(eq_end)) |-> !csync_raw); // R4
  AST_BEFORE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(vline) < $past(win_start)) |->
      (csync_raw == (($past(hpos) < $past(hsync_end)) || $past(in_vs)))); // R2
endmodule

// File: tb/eqser_csync_bench.sv
module eqser_csync_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] hpos, vline, line_len, hsync_end, vs_start, vs_end;
  logic [11:0] eq_end, serr_end, win_start, win_end;
  logic odd_field, es_disable;
  logic [1:0] mode;
  logic csync_raw, mode_illegal;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eqser_csync u_eqser_csync (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vline(vline), .odd_field(odd_field),
    .line_len(line_len), .hsync_end(hsync_end), .vs_start(vs_start), .vs_end(vs_end),
    .mode(mode), .eq_end(eq_end), .serr_end(serr_end), .win_start(win_start),
    .win_end(win_end), .es_disable(es_disable), .csync_raw(csync_raw),
    .mode_illegal(mode_illegal));

  function automatic bit ref_csync();
    int h, ph, wd;
    bit vs, win, subst;
    h  = int'(line_len) / 2;
    vs = (vline >= vs_start) && (vline < vs_end);
    if (mode == 2'b00 && odd_field)
      win = (vline == win_start && int'(hpos) >= h) ||
            (vline > win_start && vline < win_end) ||
            (vline == win_end && int'(hpos) < h);
    else
      win = (vline >= win_start) && (vline < win_end);
    subst = win && !es_disable && mode != 2'b10;
    if (!subst) return (hpos < hsync_end) || vs;
    ph = (mode != 2'b11 && int'(hpos) >= h) ? int'(hpos) - h : int'(hpos);
    wd = vs ? int'(serr_end) : int'(eq_end);
    return ph < wd;
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b (mode=%0d hpos=%0d vline=%0d odd=%0b)",
               req, act, exp, mode, hpos, vline, odd_field);
    end
  endtask

  task automatic step(input string req);
    bit e, ei;
    e  = ref_csync();
    ei = (mode == 2'b10);
    @(posedge clk); #1;
    check(req, csync_raw, e);
    check("R10", mode_illegal, ei);
  endtask

  task automatic base();
    line_len = 12'd400; hsync_end = 12'd30; vs_start = 12'd6; vs_end = 12'd9;
    eq_end = 12'd15; serr_end = 12'd170; win_start = 12'd3; win_end = 12'd12;
    es_disable = 0; mode = 2'b01; odd_field = 0; hpos = 0; vline = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd715));
    base();
    repeat (3) @(posedge clk);
    #1;
    check("R1", csync_raw, 1'b0);
    check("R1", mode_illegal, 1'b0);
    rst_n = 1'b1;
    #1;
    check("R1", csync_raw, 1'b0);

    vline = 12'd1; hpos = 12'd10; step("R2");
    hpos = 12'd31; step("R2");
    vline = 12'd4; hpos = 12'd200; step("R3");
    hpos = 12'd214; step("R3");
    hpos = 12'd215; step("R3");
    mode = 2'b11; hpos = 12'd200; step("R4");
    hpos = 12'd14; step("R4");
    vline = 12'd7; hpos = 12'd169; step("R5");
    mode = 2'b01; hpos = 12'd210; step("R5");
    vline = 12'd3; hpos = 12'd5; step("R6");
    vline = 12'd12; hpos = 12'd20; step("R6");
    vline = 12'd12; hpos = 12'd35; step("R6");
    mode = 2'b00; odd_field = 1; vline = 12'd3; hpos = 12'd10; step("R7");
    hpos = 12'd40; step("R7");
    hpos = 12'd205; step("R7");
    vline = 12'd12; hpos = 12'd20; step("R7");
    hpos = 12'd205; step("R7");
    mode = 2'b01; vline = 12'd12; hpos = 12'd205; step("R8");
    mode = 2'b11; vline = 12'd3; hpos = 12'd10; step("R8");
    mode = 2'b01; es_disable = 1; vline = 12'd5; hpos = 12'd20; step("R9");
    hpos = 12'd210; step("R9");
    es_disable = 0; mode = 2'b10; vline = 12'd5; hpos = 12'd40; step("R10");
    hpos = 12'd10; step("R10");
    mode = 2'b01; step("R10");

    for (int i = 0; i < 3000; i++) begin
      string tag;
      line_len  = 12'(100 + $urandom_range(0, 700));
      hsync_end = 12'($urandom_range(5, 60));
      eq_end    = 12'($urandom_range(2, 40));
      serr_end  = 12'($urandom_range(20, int'(line_len) / 2));
      win_start = 12'($urandom_range(0, 10));
      win_end   = 12'(int'(win_start) + $urandom_range(1, 15));
      vs_start  = 12'(int'(win_start) + $urandom_range(0, 5));
      vs_end    = 12'(int'(vs_start) + $urandom_range(0, 6));
      vline     = 12'($urandom_range(0, 30));
      hpos      = 12'($urandom_range(0, int'(line_len) - 1));
      mode      = 2'($urandom_range(0, 3));
      odd_field = 1'($urandom_range(0, 1));
      es_disable = ($urandom_range(0, 7) == 0);
      if (mode == 2'b10) tag = "R10";
      else if (es_disable) tag = "R9";
      else if (mode == 2'b00 && odd_field) tag = "R7";
      else if (mode == 2'b11) tag = "R4";
      else tag = "R3";
      step(tag);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule